// File: doc/BRIEF.md
# Indirect-Indexed Codec Register File

This block is the control register file of an audio codec. It decodes a 64-byte bus window as sixteen 32-bit direct words. Direct word 0 is a pointer: its low five bits choose one of thirty-two 8-bit indirect registers. Direct word 1 is the port through which the chosen indirect register is read or written. All other direct words are plain storage, with two exceptions. Word 2 cannot be written. Word 4 is a control word that can trigger a soft reset.

Individual indirect entries have their own access rules. Entry 3 accepts writes but always reads as zero. Entries 11 and 25 cannot be written. Entry 12 holds a fixed version code, and only one of its bits can be changed. Reads are combinational. Writes land on the next clock edge. The interrupt output exists for integration and is held low.

Top module: `codec_regfile`

## Requirements
- R1: After reset, every direct word reads 0 and every indirect entry reads 0, except entry 12, which reads 0x8A, and entry 25, which reads 0xA0.
- R2: The direct word is selected by byte address bits [5:2]. The indirect entry is selected by bits [4:0] of direct word 0, and the upper bits of word 0 do not affect the selection.
- R3: A read of direct word 1 returns the selected indirect entry, zero-extended to 32 bits. A write to word 1 stores wdata bits [7:0] into that entry.
- R4: Indirect entry 3 accepts writes but always reads as 0 through word 1.
- R5: Writes to indirect entries 11 and 25 are ignored, so those entries keep their values.
- R6: A write to indirect entry 12 stores (wdata & 0x40) | 0x8A.
- R7: Direct word 2 ignores writes and always reads 0.
- R8: A write to direct word 4 with wdata bit 0 set returns both banks to their R1 values. Word 4 then holds wdata & 0x7F.
- R9: A write to direct word 4 with bit 0 clear stores wdata & 0x7F and leaves all other state unchanged.
- R10: A write to any direct word other than 1, 2 and 4 stores all 32 bits, and a read of that word returns the stored value.
- R11: irq_o is always 0.
- R12: A read reflects the current state in the same cycle. A write becomes visible only after the clock edge on which wr_en_i is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the current cycle |
| addr_i | input | 6 | Byte address within the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| irq_o | output | 1 | Interrupt, held low |

## Verification
The bench builds the block with its default sixteen direct words and thirty-two indirect entries. At that size, every direct word and every indirect index can be swept exhaustively. This puts each special index (the write-only entry, the two read-only entries and the version entry) within reach, and each is checked next to its ordinary neighbours. Index aliasing is exercised by writing word 0 with its upper bits set. The soft reset is exercised with a written value that has bits above bit 6 set, so both the bank clearing and the masked store that follows it can be seen.

// File: rtl/codec_regfile_pkg.sv
package codec_regfile_pkg;
  localparam int unsigned IDX_WORD   = 0;
  localparam int unsigned PORT_WORD  = 1;
  localparam int unsigned STAT_WORD  = 2;
  localparam int unsigned CTRL_WORD  = 4;
  localparam logic [31:0] CTRL_MASK  = 32'h0000_007F;

  localparam int unsigned IND_WO     = 3;
  localparam int unsigned IND_RO_A   = 11;
  localparam int unsigned IND_VER    = 12;
  localparam int unsigned IND_RO_B   = 25;
  localparam logic [7:0]  VER_CODE   = 8'h8A;
  localparam logic [7:0]  ID_CODE    = 8'hA0;
  localparam logic [7:0]  VER_WMASK  = 8'h40;

  function automatic logic [7:0] ind_rst_val(int unsigned i);
    if (i == IND_VER)  return VER_CODE;
    if (i == IND_RO_B) return ID_CODE;
    return 8'h00;
  endfunction
endpackage

// File: rtl/crf_direct_bank.sv
module crf_direct_bank
  import codec_regfile_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 16,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned WSEL_W   = $clog2(NUM_WORDS)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [WSEL_W-1:0]                 wsel_i,
  input  logic [DATA_W-1:0]                 wdata_i,
  input  logic                              soft_rst_i,
  output logic [NUM_WORDS-1:0][DATA_W-1:0]  words_o
);
  localparam logic [DATA_W-1:0] CMASK = DATA_W'(CTRL_MASK);

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic hit;
    assign hit = wr_en_i && (wsel_i == WSEL_W'(w));
    if (w == PORT_WORD || w == STAT_WORD) begin : g_fixed
      // port word lives in the indirect bank; status word is read-only
      assign words_o[w] = '0;
    end else if (w == CTRL_WORD) begin : g_ctrl
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  words_o[w] <= '0;
        else if (hit) words_o[w] <= wdata_i & CMASK;
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         words_o[w] <= '0;
        else if (soft_rst_i) words_o[w] <= '0;
        else if (hit)        words_o[w] <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/crf_indirect_bank.sv
module crf_indirect_bank
  import codec_regfile_pkg::*;
#(
  parameter int unsigned NUM_IND = 32,
  parameter int unsigned IND_W   = 8,
  localparam int unsigned IDX_W  = $clog2(NUM_IND)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [IDX_W-1:0]                idx_i,
  input  logic [IND_W-1:0]                wdata_i,
  input  logic                            soft_rst_i,
  output logic [NUM_IND-1:0][IND_W-1:0]   regs_o
);
  for (genvar i = 0; i < NUM_IND; i++) begin : g_ent
    localparam logic [IND_W-1:0] RST = IND_W'(ind_rst_val(i));
    logic hit;
    assign hit = wr_en_i && (idx_i == IDX_W'(i));
    if (i == IND_RO_A || i == IND_RO_B) begin : g_ro
      assign regs_o[i] = RST;
    end else if (i == IND_VER) begin : g_ver
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         regs_o[i] <= RST;
        else if (soft_rst_i) regs_o[i] <= RST;
        else if (hit)        regs_o[i] <= (wdata_i & IND_W'(VER_WMASK)) | IND_W'(VER_CODE);
      end
    end else begin : g_rw
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         regs_o[i] <= RST;
        else if (soft_rst_i) regs_o[i] <= RST;
        else if (hit)        regs_o[i] <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/crf_read_mux.sv
module crf_read_mux
  import codec_regfile_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_IND   = 32,
  parameter int unsigned IND_W     = 8,
  localparam int unsigned WSEL_W   = $clog2(NUM_WORDS),
  localparam int unsigned IDX_W    = $clog2(NUM_IND)
) (
  input  logic [NUM_WORDS-1:0][DATA_W-1:0] words_i,
  input  logic [NUM_IND-1:0][IND_W-1:0]    regs_i,
  input  logic [WSEL_W-1:0]                wsel_i,
  input  logic [IDX_W-1:0]                 idx_i,
  output logic [DATA_W-1:0]                rdata_o
);
  always_comb begin
    if (wsel_i != WSEL_W'(PORT_WORD))      rdata_o = words_i[wsel_i];
    else if (idx_i == IDX_W'(IND_WO))      rdata_o = '0;
    else                                   rdata_o = DATA_W'(regs_i[idx_i]);
  end
endmodule

// File: rtl/codec_regfile.sv
module codec_regfile
  import codec_regfile_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_IND   = 32,
  parameter int unsigned IND_W     = 8,
  localparam int unsigned WSEL_W   = $clog2(NUM_WORDS),
  localparam int unsigned IDX_W    = $clog2(NUM_IND),
  localparam int unsigned ADDR_W   = WSEL_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [WSEL_W-1:0]                wsel;
  logic [IDX_W-1:0]                 idx;
  logic                             soft_rst;
  logic                             ind_wr;
  logic [NUM_WORDS-1:0][DATA_W-1:0] word_q;
  logic [NUM_IND-1:0][IND_W-1:0]    ind_q;

  assign wsel     = addr_i[ADDR_W-1:2];
  assign idx      = word_q[IDX_WORD][IDX_W-1:0];
  assign soft_rst = wr_en_i && (wsel == WSEL_W'(CTRL_WORD)) && wdata_i[0];
  assign ind_wr   = wr_en_i && (wsel == WSEL_W'(PORT_WORD));
  assign irq_o    = 1'b0;

  crf_direct_bank #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W)) u_dir (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wsel_i(wsel),
    .wdata_i(wdata_i), .soft_rst_i(soft_rst), .words_o(word_q)
  );

  crf_indirect_bank #(.NUM_IND(NUM_IND), .IND_W(IND_W)) u_ind (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(ind_wr), .idx_i(idx),
    .wdata_i(wdata_i[IND_W-1:0]), .soft_rst_i(soft_rst), .regs_o(ind_q)
  );

  crf_read_mux #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W), .NUM_IND(NUM_IND), .IND_W(IND_W)) u_rd (
    .words_i(word_q), .regs_i(ind_q), .wsel_i(wsel), .idx_i(idx), .rdata_o(rdata_o)
  );
endmodule

// File: rtl/codec_regfile_chk.sv
module codec_regfile_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [5:0]  addr_i,
  input logic [31:0] wdata_i,
  input logic        irq_i,
  input logic [4:0]  idx_i,
  input logic [31:0] word2_i,
  input logic [31:0] word4_i,
  input logic [7:0]  ind11_i,
  input logic [7:0]  ind12_i,
  input logic [7:0]  ind25_i
);
  a_r11_irq_low: assert property (@(posedge clk_i) disable iff (!rst_ni) irq_i == 1'b0);

  a_r2_index_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i[5:2] == 4'd0) |=> idx_i == $past(wdata_i[4:0]));

  a_r5_ro_entry_11: assert property (@(posedge clk_i) disable iff (!rst_ni) ind11_i == 8'h00);
  a_r5_ro_entry_25: assert property (@(posedge clk_i) disable iff (!rst_ni) ind25_i == 8'hA0);

  a_r6_version_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ind12_i & 8'hBF) == 8'h8A);

  a_r7_status_zero: assert property (@(posedge clk_i) disable iff (!rst_ni) word2_i == 32'h0);

  a_r8_soft_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i[5:2] == 4'd4 && wdata_i[0])
    |=> (idx_i == 5'd0) && (word4_i == ($past(wdata_i) & 32'h7F)) && (ind12_i == 8'h8A));

  a_r9_ctrl_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i[5:2] == 4'd4 && !wdata_i[0]) |=> word4_i == ($past(wdata_i) & 32'h7F));
endmodule

bind codec_regfile codec_regfile_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .irq_i(irq_o), .idx_i(word_q[0][4:0]),
  .word2_i(word_q[2]), .word4_i(word_q[4]),
  .ind11_i(ind_q[11]), .ind12_i(ind_q[12]), .ind25_i(ind_q[25])
);

// File: tb/codec_regfile_tb.sv
module codec_regfile_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] dm [16];
  logic [7:0]  im [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_regfile u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic model_reset();
    for (int i = 0; i < 16; i++) dm[i] = '0;
    for (int i = 0; i < 32; i++) im[i] = 8'h00;
    im[12] = 8'h8A;
    im[25] = 8'hA0;
  endtask

  function automatic logic [31:0] model_rd(logic [5:0] a);
    int w = int'(a[5:2]);
    int ix = int'(dm[0][4:0]);
    if (w != 1) return dm[w];
    if (ix == 3) return 32'h0;
    return {24'h0, im[ix]};
  endfunction

  task automatic model_wr(logic [5:0] a, logic [31:0] d);
    int w = int'(a[5:2]);
    int ix = int'(dm[0][4:0]);
    if (w == 1) begin
      if (ix == 12) im[ix] = (d[7:0] & 8'h40) | 8'h8A;
      else if (ix != 11 && ix != 25) im[ix] = d[7:0];
    end else if (w == 4) begin
      if (d[0]) model_reset();
      dm[4] = d & 32'h7F;
    end else if (w != 2) begin
      dm[w] = d;
    end
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [5:0] a, string tag);
    addr_i = a;
    #1;
    check(tag, rdata_o, model_rd(a));
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk);
    #1;
    wr_en_i = 1'b0;
    model_wr(a, d);
  endtask

  function automatic string ind_tag(int ix);
    if (ix == 3) return "R4";
    if (ix == 11 || ix == 25) return "R5";
    if (ix == 12) return "R6";
    return "R3";
  endfunction

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;

    // R1: reset state of both banks
    for (int w = 0; w < 16; w++) rd(6'(w * 4), "R1");
    for (int ix = 0; ix < 32; ix++) begin
      wr(6'h00, 32'(ix));
      rd(6'h04, "R1");
    end
    wr(6'h00, 32'h0);
    check("R11", {31'h0, irq_o}, 32'h0);

    // R3..R6: every indirect index, two data patterns
    for (int p = 0; p < 2; p++) begin
      for (int ix = 0; ix < 32; ix++) begin
        wr(6'h00, 32'(ix));
        wr(6'h04, 32'hABCD_0000 | 32'((ix * 37 + 8'h5C + p * 8'h91) & 8'hFF));
        rd(6'h04, ind_tag(ix));
        // R2: upper bits of word 0 do not alias the index
        wr(6'h00, 32'hFFFF_FFE0 | 32'(ix));
        rd(6'h04, "R2");
        rd(6'h00, "R2");
      end
    end

    // R6: bit 6 set and clear on entry 12
    wr(6'h00, 32'd12);
    wr(6'h04, 32'hFF);
    check("R6", rdata_o, 32'hCA);
    wr(6'h04, 32'h00);
    check("R6", rdata_o, 32'h8A);

    // R7, R10: all direct words
    for (int w = 0; w < 16; w++) begin
      if (w != 1 && w != 4) begin
        wr(6'(w * 4), 32'h1357_9BDF ^ (32'(w) << 20) ^ 32'(w * 3));
        rd(6'(w * 4), (w == 2) ? "R7" : "R10");
      end
    end
    // R2: sub-word byte offsets select the same word
    rd(6'h17, "R2");
    rd(6'h3D, "R2");

    // R12: write visible only after the edge
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = 6'h14; wdata_i = 32'hDEAD_BEEF;
    #1;
    check("R12", rdata_o, dm[5]);
    @(posedge clk);
    #1;
    wr_en_i = 1'b0;
    model_wr(6'h14, 32'hDEAD_BEEF);
    check("R12", rdata_o, 32'hDEAD_BEEF);

    // R9: control write without reset
    wr(6'h00, 32'd7);
    wr(6'h04, 32'h66);
    wr(6'h10, 32'hFFFF_FFFE);
    rd(6'h10, "R9");
    check("R9", rdata_o, 32'h7E);
    rd(6'h00, "R9");
    rd(6'h04, "R9");
    rd(6'h14, "R9");

    // R8: soft reset then masked store
    wr(6'h10, 32'hFFFF_FF81);
    rd(6'h10, "R8");
    check("R8", rdata_o, 32'h01);
    for (int w = 0; w < 16; w++) rd(6'(w * 4), "R8");
    for (int ix = 0; ix < 32; ix++) begin
      wr(6'h00, 32'(ix));
      rd(6'h04, "R8");
    end
    wr(6'h10, 32'h0000_00FF);
    rd(6'h10, "R8");
    check("R8", rdata_o, 32'h7F);
    check("R11", {31'h0, irq_o}, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule